// File: doc/BRIEF.md
# Remote DMA Write Address Generator

This block produces the packet-RAM address for each host write that fills transmit data into a shared packet buffer. The host loads a start address and a transfer length once, then streams data; every write strobe moves the address on by one byte, or by two bytes when the host path is sixteen bits wide. A remaining-length counter runs down with each write, and a done flag shows when the programmed length has been written.

Addresses are sixteen bits: a page number in the upper byte and an offset within the page in the lower byte. The transmit area starts at a fixed first page (0x40 by default) and ends one page below the page at which the receive area begins, given by the `rx_start_page` input. In linear mode the address simply keeps counting through the whole memory, which allows full memory testing; keeping transmit data out of the receive area is then the host's job. In ring mode an address that would step out of the top of the transmit area folds back to the first transmit page with the same offset, so the host can keep writing without reloading the start address.

Top module: `rdwag_top`

## Requirements
- R1: After synchronous reset, `wr_addr` is 0x0000, `remaining` is 0 and `done` is 1.
- R2: When `load` is high at a clock edge, `wr_addr` takes `start_addr` and `remaining` takes `byte_cnt` after that edge; `load` takes priority over `wr_en` in the same cycle.
- R3: With `word_mode` = 0, each edge with `wr_en` = 1 (and `load` = 0) adds 1 to `wr_addr`; with `wr_en` = 0 and `load` = 0 neither `wr_addr` nor `remaining` changes.
- R4: With `word_mode` = 1, each write adds 2 to `wr_addr`.
- R5: With `ring_en` = 0 the address advances past the end of the transmit area into the receive area and wraps from 0xFFFF (byte) or 0xFFFE (word) to the low end of memory modulo 2^16.
- R6: With ring mode active, a write whose address page lies in the transmit area (page >= 0x40 and < `rx_start_page`) and whose stepped address reaches page `rx_start_page` or above produces page 0x40 in the upper byte, keeping the stepped low byte (e.g. 0x45FF byte step with `rx_start_page` = 0x46 gives 0x4000; 0x45FF word step gives 0x4001).
- R7: Ring mode is active only when `ring_en` = 1 and `rx_start_page` > 0x40; otherwise the address advances linearly as in R5.
- R8: In ring mode a write from an address whose page is outside the transmit area advances linearly.
- R9: Each write lowers `remaining` by the step (1 or 2) and never below 0; a write with `remaining` = 0 leaves it at 0.
- R10: `done` is 1 exactly when `remaining` is 0, including directly after a load with `byte_cnt` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Load start address and length |
| start_addr | input | 16 | Start address (page, offset) |
| byte_cnt | input | 16 | Transfer length in bytes |
| wr_en | input | 1 | One host write this cycle |
| word_mode | input | 1 | 1: 16-bit writes (step 2), 0: byte writes |
| ring_en | input | 1 | Fold writes inside the transmit area |
| rx_start_page | input | 8 | First page of the receive area |
| wr_addr | output | 16 | Address for the current write |
| remaining | output | 16 | Bytes still to be written |
| done | output | 1 | Programmed length fully written |

## Verification
The hardest situation to reach is the fold at the top of the transmit area: the address must sit on the last byte or word of page `rx_start_page - 1` at the moment a write arrives with ring mode on and a non-degenerate receive start. Random start addresses are therefore drawn mostly from page and offset values next to the boundaries (0x3F, 0x40, the last transmit page, the receive start page, 0xFF; offsets 0xFD to 0xFF), and the receive start is drawn from a narrow band around 0x40, so folds, degenerate settings and out-of-area starts all occur often. Directed cases pin down the exact fold results, the 0xFFFF linear wrap and counter saturation.

// File: rtl/rdwag_pkg.sv
package rdwag_pkg;

    localparam int PAGE_W = 8;
    localparam int ADDR_W = 2 * PAGE_W;

    typedef logic [PAGE_W-1:0] page_t;

    typedef struct packed {
        page_t page;
        page_t off;
    } buf_addr_t;

    // Address increment for one host write.
    function automatic logic [ADDR_W-1:0] addr_step(input logic word_mode);
        return word_mode ? ADDR_W'(2) : ADDR_W'(1);
    endfunction

    // Ring folding is meaningful only with a non-empty transmit area.
    function automatic logic ring_usable(input logic ring_en, input page_t rx_page,
                                         input page_t first_page);
        return ring_en && (rx_page > first_page);
    endfunction

endpackage

// File: rtl/rdwag_next.sv
module rdwag_next
    import rdwag_pkg::*;
#(
    parameter page_t TX_FIRST_PAGE = 8'h40
) (
    input  buf_addr_t cur,
    input  logic      word_mode,
    input  logic      ring_en,
    input  page_t     rx_page,
    output buf_addr_t nxt
);
    logic [ADDR_W-1:0] sum_v;
    buf_addr_t         sum;
    logic              ring_ok;
    logic              in_tx;
    logic              fold;

    always_comb begin
        sum_v   = cur + addr_step(word_mode);
        sum     = buf_addr_t'(sum_v);
        ring_ok = ring_usable(ring_en, rx_page, TX_FIRST_PAGE);
        in_tx   = (cur.page >= TX_FIRST_PAGE) && (cur.page < rx_page);
        fold    = ring_ok && in_tx && (sum.page >= rx_page);
        nxt     = sum;
        if (fold) begin
            nxt.page = TX_FIRST_PAGE;
        end
    end
endmodule

// File: rtl/rdwag_count.sv
module rdwag_count
    import rdwag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] len,
    input  logic              wr_en,
    input  logic              word_mode,
    output logic [ADDR_W-1:0] rem,
    output logic              empty
);
    logic [ADDR_W-1:0] step;

    always_comb begin
        step  = addr_step(word_mode);
        empty = (rem == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
        end else if (load) begin
            rem <= len;
        end else if (wr_en) begin
            rem <= (rem > step) ? rem - step : '0;
        end
    end
endmodule

// File: rtl/rdwag_top.sv
module rdwag_top
    import rdwag_pkg::*;
#(
    parameter page_t TX_FIRST_PAGE = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] byte_cnt,
    input  logic              wr_en,
    input  logic              word_mode,
    input  logic              ring_en,
    input  logic [PAGE_W-1:0] rx_start_page,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] remaining,
    output logic              done
);
    buf_addr_t addr_q;
    buf_addr_t addr_nxt;

    rdwag_next #(.TX_FIRST_PAGE(TX_FIRST_PAGE)) u_next (
        .cur       (addr_q),
        .word_mode (word_mode),
        .ring_en   (ring_en),
        .rx_page   (rx_start_page),
        .nxt       (addr_nxt)
    );

    rdwag_count u_count (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .len       (byte_cnt),
        .wr_en     (wr_en),
        .word_mode (word_mode),
        .rem       (remaining),
        .empty     (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= buf_addr_t'(start_addr);
        end else if (wr_en) begin
            addr_q <= addr_nxt;
        end
    end

    assign wr_addr = addr_q;
endmodule

// File: rtl/rdwag_chk.sv
module rdwag_chk (
    input logic        clk,
    input logic        rst,
    input logic        load,
    input logic [15:0] start_addr,
    input logic [15:0] byte_cnt,
    input logic        wr_en,
    input logic        word_mode,
    input logic        ring_en,
    input logic [7:0]  rx_start_page,
    input logic [15:0] wr_addr,
    input logic [15:0] remaining,
    input logic        done
);
    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        load |=> (wr_addr == $past(start_addr)) && (remaining == $past(byte_cnt)));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !wr_en) |=> $stable(wr_addr) && $stable(remaining));

    a_r7_degenerate_linear: assert property (@(posedge clk) disable iff (rst)
        (!load && wr_en && !word_mode && rx_start_page <= 8'h40)
        |=> wr_addr == $past(wr_addr) + 16'd1);

    a_r6_stay_in_tx: assert property (@(posedge clk) disable iff (rst)
        (!load && wr_en && ring_en && rx_start_page > 8'h40 &&
         wr_addr[15:8] >= 8'h40 && wr_addr[15:8] < rx_start_page)
        |=> (wr_addr[15:8] >= 8'h40) && (wr_addr[15:8] < $past(rx_start_page)));

    a_r9_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (!load && wr_en && remaining == 16'd0) |=> remaining == 16'd0);

    a_r9_decreases: assert property (@(posedge clk) disable iff (rst)
        (!load && wr_en && remaining != 16'd0) |=> remaining < $past(remaining));

    a_r10_zero_load_done: assert property (@(posedge clk) disable iff (rst)
        (load && byte_cnt == 16'd0) |=> done);
endmodule

bind rdwag_top rdwag_chk u_chk (.*);

// File: tb/rdwag_top_tb.sv
`timescale 1ns/1ps
module rdwag_top_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        load;
    logic [15:0] start_addr;
    logic [15:0] byte_cnt;
    logic        wr_en;
    logic        word_mode;
    logic        ring_en;
    logic [7:0]  rx_start_page;
    logic [15:0] wr_addr;
    logic [15:0] remaining;
    logic        done;

    int checks = 0;
    int fails  = 0;
    logic [15:0] m_addr;
    logic [15:0] m_rem;

    always #2.5 clk = ~clk;

    rdwag_top u_dut (.*);

    function automatic logic [15:0] ref_next(input logic [15:0] a, input logic w,
                                             input logic r, input logic [7:0] rx);
        logic [15:0] s;
        s = a + (w ? 16'd2 : 16'd1);
        if (r && rx > 8'h40 && a[15:8] >= 8'h40 && a[15:8] < rx && s[15:8] >= rx)
            s = {8'h40, s[7:0]};
        return s;
    endfunction

    function automatic logic [15:0] ref_rem(input logic [15:0] c, input logic w);
        logic [15:0] st;
        st = w ? 16'd2 : 16'd1;
        return (c > st) ? c - st : 16'd0;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle, update the model, compare after the edge.
    task automatic cyc(input logic ld, input logic [15:0] sa, input logic [15:0] bc,
                       input logic we, input logic w, input logic r, input logic [7:0] rx,
                       input string req);
        @(negedge clk);
        load = ld; start_addr = sa; byte_cnt = bc; wr_en = we;
        word_mode = w; ring_en = r; rx_start_page = rx;
        if (ld) begin
            m_addr = sa; m_rem = bc;
        end else if (we) begin
            m_addr = ref_next(m_addr, w, r, rx);
            m_rem  = ref_rem(m_rem, w);
        end
        @(posedge clk); #1;
        check(req, wr_addr, m_addr);
        check(req, remaining, m_rem);
        check("R10", {15'd0, done}, {15'd0, m_rem == 16'd0});
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        rst = 1'b1; load = 0; start_addr = 0; byte_cnt = 0; wr_en = 0;
        word_mode = 0; ring_en = 0; rx_start_page = 8'h46;
        repeat (3) @(posedge clk);
        #1;
        check("R1", wr_addr, 16'h0000);
        check("R1", remaining, 16'h0000);
        check("R1", {15'd0, done}, 16'd1);
        @(negedge clk); rst = 1'b0;
        m_addr = 16'h0; m_rem = 16'h0;

        // R2 load wins over a simultaneous write
        cyc(1, 16'h45FE, 16'd5, 1, 0, 1, 8'h46, "R2");
        check("R2", wr_addr, 16'h45FE);
        cyc(0, 0, 0, 0, 0, 1, 8'h46, "R3");
        cyc(0, 0, 0, 1, 0, 1, 8'h46, "R3");
        check("R3", wr_addr, 16'h45FF);
        cyc(0, 0, 0, 1, 0, 1, 8'h46, "R6");
        check("R6", wr_addr, 16'h4000);
        // R6 word step across the top
        cyc(1, 16'h45FF, 16'd3, 0, 0, 0, 8'h46, "R2");
        cyc(0, 0, 0, 1, 1, 1, 8'h46, "R6");
        check("R6", wr_addr, 16'h4001);
        check("R9", remaining, 16'd1);
        cyc(0, 0, 0, 1, 1, 1, 8'h46, "R9");
        check("R9", remaining, 16'd0);
        cyc(0, 0, 0, 1, 1, 1, 8'h46, "R9");
        check("R4", wr_addr, 16'h4005);
        // R5 linear past the transmit end and through 0xFFFF
        cyc(1, 16'h45FF, 16'd9, 0, 0, 0, 8'h46, "R2");
        cyc(0, 0, 0, 1, 0, 0, 8'h46, "R5");
        check("R5", wr_addr, 16'h4600);
        cyc(1, 16'hFFFF, 16'd0, 0, 0, 0, 8'h46, "R10");
        check("R10", {15'd0, done}, 16'd1);
        cyc(0, 0, 0, 1, 0, 0, 8'h46, "R5");
        check("R5", wr_addr, 16'h0000);
        // R7 degenerate receive start
        cyc(1, 16'h3FFF, 16'd4, 0, 0, 0, 8'h40, "R2");
        cyc(0, 0, 0, 1, 0, 1, 8'h40, "R7");
        check("R7", wr_addr, 16'h4000);
        // R8 outside the area in ring mode
        cyc(1, 16'h46FF, 16'd4, 0, 0, 0, 8'h46, "R2");
        cyc(0, 0, 0, 1, 0, 1, 8'h46, "R8");
        check("R8", wr_addr, 16'h4700);

        // Constrained random around the boundaries
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] rx, pg, of;
            logic ld, we, w, r;
            string req;
            rx = 8'h3E + 8'($urandom_range(0, 10));
            case ($urandom_range(0, 5))
                0: pg = 8'h3F;
                1: pg = 8'h40;
                2: pg = rx - 8'd1;
                3: pg = rx;
                4: pg = 8'hFF;
                default: pg = 8'($urandom);
            endcase
            of = ($urandom_range(0, 3) != 0) ? 8'hFD + 8'($urandom_range(0, 2)) : 8'($urandom);
            ld = ($urandom_range(0, 7) == 0);
            we = ($urandom_range(0, 3) != 0);
            w  = 1'($urandom);
            r  = ($urandom_range(0, 3) != 0);
            if (ld) req = "R2";
            else if (!we) req = "R3";
            else if (r && rx > 8'h40) req = "R6";
            else if (r) req = "R7";
            else if (w) req = "R4";
            else req = "R5";
            cyc(ld, {pg, of}, 16'($urandom_range(0, 12)), we, w, r, rx, req);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule